// File: doc/BRIEF.md
# Delayed-Write Store Pipeline for a Direct-Mapped Cache

This block is the write path of a direct-mapped cache, split into two stages. In the first stage a request is looked up in the tag array. A store that hits is then parked in a single holding slot instead of being written at once. The parked store is written into the data array in a later cycle, normally the same cycle in which the next store is having its own tag looked up. As a result a stream of stores costs one data-array cycle per store, and the tag check never has to wait for a write.

Loads read the data array directly. Any bytes still waiting in the holding slot for the same word are substituted into the load result, so a load never sees stale data. Any miss, from a load or a store, empties the slot by committing its write before the refill machinery takes over. The block reports the missing address and whether the miss came from a store.

A parameter selects whether the data array has one shared port or separate read and write ports. With a shared port, the parked write waits out load cycles. With separate ports, it commits on any cycle.

Top module: `store_delay_pipe`

## Requirements
- R1: After reset the holding slot is empty, so an idle cycle issues no data-array write, and `rsp_valid` and `miss_valid` are low.
- R2: A store whose tag check hits is not written in its own cycle. It is written exactly once in a later cycle, in request order. The write carries its index (address bits [INDEX_W+1:2] for a 32-bit word), its data, and its 4 byte enables, where enable bit i covers data bits [8i+7:8i].
- R3: When a store hits while the slot holds an earlier store, the earlier store is written to the data array in that same cycle and the new store takes its place.
- R4: Loads never enter the slot. In shared-port mode a load hit leaves the slot's address, data and enables unchanged.
- R5: In shared-port mode no data-array write is issued in a cycle that carries a load hit.
- R6: A pending store commits in the first cycle that is not a load hit (in separate-port mode, the first cycle of any kind). After idle cycles nothing is left pending.
- R7: On a miss of either kind the pending store, if any, is written in that miss cycle. A store that misses is not retained, so the following idle cycle issues no write.
- R8: A request whose tag check misses raises `miss_valid` in the same cycle, with its address on `miss_addr` and its kind on `miss_store`. A load miss produces no response.
- R9: A load hit yields `rsp_valid` one cycle later. The response is the array word, with each byte enabled in the pending store replaced by that store's byte when the word addresses (address bits above bit 1) are equal.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| req_valid | input | 1 | Request present this cycle |
| req_store | input | 1 | 1 = store, 0 = load |
| req_addr | input | ADDR_W | Byte address of the request |
| req_wdata | input | DATA_W | Store data |
| req_be | input | DATA_W/8 | Store byte enables |
| tag_hit | input | 1 | Tag-array comparison result for req_addr |
| rd_index | output | INDEX_W | Data-array read index for the request |
| arr_rdata | input | DATA_W | Data-array word at rd_index, same cycle |
| dwr_en | output | 1 | Data-array write strobe |
| dwr_index | output | INDEX_W | Data-array write index |
| dwr_data | output | DATA_W | Data-array write data |
| dwr_be | output | DATA_W/8 | Data-array byte write enables |
| rsp_valid | output | 1 | Load response valid |
| rsp_data | output | DATA_W | Load response word |
| miss_valid | output | 1 | Tag check missed this cycle |
| miss_addr | output | ADDR_W | Address of the missing request |
| miss_store | output | 1 | Missing request was a store |

## Verification
The bench builds the block with ADDR_W = 12, INDEX_W = 4, a 32-bit word and the shared-port variant. The small index lets random addresses drawn from eight words fold onto four array lines under two tags. That brings within reach tag misses with drains, refills that change a line's owner, and loads that land on a word with a parked partial store. The shared-port choice exposes parked writes that are held back across runs of loads and released by the next free cycle.

// File: rtl/sdw_pkg.sv
package sdw_pkg;

   typedef enum logic [2:0] {
      OP_IDLE,
      OP_LD_HIT,
      OP_LD_MISS,
      OP_ST_HIT,
      OP_ST_MISS
   } op_e;

   function automatic op_e classify(input logic v, input logic st, input logic hit);
      if (!v)
         return OP_IDLE;
      if (st)
         return hit ? OP_ST_HIT : OP_ST_MISS;
      return hit ? OP_LD_HIT : OP_LD_MISS;
   endfunction

   function automatic logic is_miss(input op_e op);
      return (op == OP_LD_MISS) || (op == OP_ST_MISS);
   endfunction

endpackage

// File: rtl/sdw_merge.sv
module sdw_merge #(
   parameter int DATA_W = 32,
   localparam int BE_W = DATA_W / 8
) (
   input  logic [DATA_W-1:0] base,
   input  logic [DATA_W-1:0] over,
   input  logic [BE_W-1:0]   be,
   input  logic              sel,
   output logic [DATA_W-1:0] merged
);

   for (genvar b = 0; b < BE_W; b++) begin : g_byte
      assign merged[8*b +: 8] = (sel && be[b]) ? over[8*b +: 8] : base[8*b +: 8];
   end

endmodule

// File: rtl/sdw_pend.sv
module sdw_pend
   import sdw_pkg::*;
#(
   parameter int WORD_W      = 14,
   parameter int DATA_W      = 32,
   parameter int SHARED_PORT = 1,
   localparam int BE_W = DATA_W / 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  op_e               op,
   input  logic [WORD_W-1:0] in_word,
   input  logic [DATA_W-1:0] in_data,
   input  logic [BE_W-1:0]   in_be,
   output logic              pend_v,
   output logic [WORD_W-1:0] pend_word,
   output logic [DATA_W-1:0] pend_data,
   output logic [BE_W-1:0]   pend_be,
   output logic              commit
);

   logic port_free;

   if (SHARED_PORT != 0) begin : g_shared
      assign port_free = (op != OP_LD_HIT);
   end else begin : g_split
      assign port_free = 1'b1;
   end

   assign commit = pend_v && port_free;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend_v    <= 1'b0;
         pend_word <= '0;
         pend_data <= '0;
         pend_be   <= '0;
      end else if (op == OP_ST_HIT) begin
         pend_v    <= 1'b1;
         pend_word <= in_word;
         pend_data <= in_data;
         pend_be   <= in_be;
      end else if (commit) begin
         pend_v    <= 1'b0;
      end
   end

   // R2: a hitting store is parked for the next cycle
   p_store_parked_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (op == OP_ST_HIT) |=> (pend_v && pend_word == $past(in_word)
                             && pend_data == $past(in_data) && pend_be == $past(in_be)));

   // R3: an occupied slot is released when a new store hits
   p_overlap_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (op == OP_ST_HIT && pend_v) |-> commit);

   // R7: a miss leaves the slot empty
   p_drain_r7: assert property (@(posedge clk) disable iff (!rst_n)
      is_miss(op) |=> !pend_v);

   // R6: an uncommitted entry is kept intact
   p_no_loss_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (pend_v && !commit) |=> (pend_v && $stable(pend_data) && $stable(pend_be)
                               && $stable(pend_word)));

   if (SHARED_PORT != 0) begin : g_chk_shared
      // R4: loads leave the slot untouched
      p_load_holds_r4: assert property (@(posedge clk) disable iff (!rst_n)
         (op == OP_LD_HIT) |=> ($stable(pend_v) && $stable(pend_word)
                                && $stable(pend_data) && $stable(pend_be)));
   end else begin : g_chk_split
      // R4: loads never occupy the slot
      p_load_empty_r4: assert property (@(posedge clk) disable iff (!rst_n)
         (op == OP_LD_HIT) |=> !pend_v);
   end

endmodule

// File: rtl/sdw_load_rsp.sv
module sdw_load_rsp
   import sdw_pkg::*;
#(
   parameter int WORD_W = 14,
   parameter int DATA_W = 32,
   localparam int BE_W = DATA_W / 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  op_e               op,
   input  logic [WORD_W-1:0] req_word,
   input  logic [DATA_W-1:0] arr_rdata,
   input  logic              pend_v,
   input  logic [WORD_W-1:0] pend_word,
   input  logic [DATA_W-1:0] pend_data,
   input  logic [BE_W-1:0]   pend_be,
   output logic              rsp_valid,
   output logic [DATA_W-1:0] rsp_data
);

   logic              fwd_sel;
   logic [DATA_W-1:0] fwd_word;

   assign fwd_sel = pend_v && (pend_word == req_word);

   sdw_merge #(.DATA_W(DATA_W)) u_merge (
      .base   (arr_rdata),
      .over   (pend_data),
      .be     (pend_be),
      .sel    (fwd_sel),
      .merged (fwd_word)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rsp_valid <= 1'b0;
         rsp_data  <= '0;
      end else begin
         rsp_valid <= (op == OP_LD_HIT);
         if (op == OP_LD_HIT)
            rsp_data <= fwd_word;
      end
   end

   // R9: every load hit is answered one cycle later
   p_rsp_follows_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (op == OP_LD_HIT) |=> rsp_valid);

   // R8: nothing else produces a response
   p_no_stray_rsp_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (op != OP_LD_HIT) |=> !rsp_valid);

endmodule

// File: rtl/store_delay_pipe.sv
module store_delay_pipe
   import sdw_pkg::*;
#(
   parameter int ADDR_W      = 16,
   parameter int DATA_W      = 32,
   parameter int INDEX_W     = 6,
   parameter int SHARED_PORT = 1,
   localparam int BE_W     = DATA_W / 8,
   localparam int OFFSET_W = $clog2(BE_W),
   localparam int WORD_W   = ADDR_W - OFFSET_W
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               req_valid,
   input  logic               req_store,
   input  logic [ADDR_W-1:0]  req_addr,
   input  logic [DATA_W-1:0]  req_wdata,
   input  logic [BE_W-1:0]    req_be,
   input  logic               tag_hit,
   output logic [INDEX_W-1:0] rd_index,
   input  logic [DATA_W-1:0]  arr_rdata,
   output logic               dwr_en,
   output logic [INDEX_W-1:0] dwr_index,
   output logic [DATA_W-1:0]  dwr_data,
   output logic [BE_W-1:0]    dwr_be,
   output logic               rsp_valid,
   output logic [DATA_W-1:0]  rsp_data,
   output logic               miss_valid,
   output logic [ADDR_W-1:0]  miss_addr,
   output logic               miss_store
);

   if (DATA_W < 16 || (DATA_W % 8) != 0) begin : g_bad_data_w
      $error("store_delay_pipe: DATA_W must be a multiple of 8, at least 16");
   end
   if ((BE_W & (BE_W - 1)) != 0) begin : g_bad_be_w
      $error("store_delay_pipe: DATA_W/8 must be a power of two");
   end
   if (INDEX_W < 1 || INDEX_W + OFFSET_W >= ADDR_W) begin : g_bad_index_w
      $error("store_delay_pipe: INDEX_W must leave at least one tag bit");
   end
   if (SHARED_PORT != 0 && SHARED_PORT != 1) begin : g_bad_port
      $error("store_delay_pipe: SHARED_PORT must be 0 or 1");
   end

   op_e               op;
   logic [WORD_W-1:0] req_word;
   logic              pend_v;
   logic [WORD_W-1:0] pend_word;
   logic [DATA_W-1:0] pend_data;
   logic [BE_W-1:0]   pend_be;
   logic              commit;

   assign op       = classify(req_valid, req_store, tag_hit);
   assign req_word = req_addr[ADDR_W-1:OFFSET_W];
   assign rd_index = req_word[INDEX_W-1:0];

   sdw_pend #(
      .WORD_W      (WORD_W),
      .DATA_W      (DATA_W),
      .SHARED_PORT (SHARED_PORT)
   ) u_pend (
      .clk       (clk),
      .rst_n     (rst_n),
      .op        (op),
      .in_word   (req_word),
      .in_data   (req_wdata),
      .in_be     (req_be),
      .pend_v    (pend_v),
      .pend_word (pend_word),
      .pend_data (pend_data),
      .pend_be   (pend_be),
      .commit    (commit)
   );

   sdw_load_rsp #(
      .WORD_W (WORD_W),
      .DATA_W (DATA_W)
   ) u_rsp (
      .clk       (clk),
      .rst_n     (rst_n),
      .op        (op),
      .req_word  (req_word),
      .arr_rdata (arr_rdata),
      .pend_v    (pend_v),
      .pend_word (pend_word),
      .pend_data (pend_data),
      .pend_be   (pend_be),
      .rsp_valid (rsp_valid),
      .rsp_data  (rsp_data)
   );

   assign dwr_en     = commit;
   assign dwr_index  = pend_word[INDEX_W-1:0];
   assign dwr_data   = pend_data;
   assign dwr_be     = pend_be;

   assign miss_valid = is_miss(op);
   assign miss_addr  = req_addr;
   assign miss_store = req_store;

   // R7: a miss with a parked store writes it out in the miss cycle
   p_miss_drains_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !tag_hit && pend_v) |-> dwr_en);

   // R8: a missing request is reported at once
   p_miss_flag_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !tag_hit) |-> (miss_valid && miss_addr == req_addr));

   // R2: a store is never written in its own tag-check cycle from an empty slot
   p_no_same_cycle_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (!pend_v) |-> !dwr_en);

   if (SHARED_PORT != 0) begin : g_port_chk
      // R5: the shared port is not written while a load reads it
      p_port_busy_r5: assert property (@(posedge clk) disable iff (!rst_n)
         (req_valid && !req_store && tag_hit) |-> !dwr_en);
   end

endmodule

// File: tb/test_store_delay_pipe.sv
`timescale 1ns/1ps
module test_store_delay_pipe;

   localparam int AW = 12;
   localparam int IW = 4;
   localparam int TW = AW - IW - 2;

   typedef struct {
      logic [IW-1:0] idx;
      logic [31:0]   d;
      logic [3:0]    be;
   } wr_t;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          req_valid = 1'b0;
   logic          req_store = 1'b0;
   logic [AW-1:0] req_addr = '0;
   logic [31:0]   req_wdata = '0;
   logic [3:0]    req_be = '0;
   logic          tag_hit = 1'b0;
   logic [IW-1:0] rd_index;
   logic [31:0]   arr_rdata;
   logic          dwr_en;
   logic [IW-1:0] dwr_index;
   logic [31:0]   dwr_data;
   logic [3:0]    dwr_be;
   logic          rsp_valid;
   logic [31:0]   rsp_data;
   logic          miss_valid;
   logic [AW-1:0] miss_addr;
   logic          miss_store;

   logic [31:0]   mem    [2**IW];
   logic [31:0]   refidx [2**IW];
   logic [TW-1:0] tagm   [2**IW];

   wr_t           wq[$];
   logic [31:0]   rq[$];
   logic [AW:0]   mq[$];
   int            nchk = 0;
   int            nfail = 0;

   always #4 clk = ~clk;

   assign arr_rdata = mem[rd_index];

   store_delay_pipe #(
      .ADDR_W (AW), .DATA_W (32), .INDEX_W (IW), .SHARED_PORT (1)
   ) i_store_delay_pipe (
      .clk (clk), .rst_n (rst_n), .req_valid (req_valid), .req_store (req_store),
      .req_addr (req_addr), .req_wdata (req_wdata), .req_be (req_be),
      .tag_hit (tag_hit), .rd_index (rd_index), .arr_rdata (arr_rdata),
      .dwr_en (dwr_en), .dwr_index (dwr_index), .dwr_data (dwr_data),
      .dwr_be (dwr_be), .rsp_valid (rsp_valid), .rsp_data (rsp_data),
      .miss_valid (miss_valid), .miss_addr (miss_addr), .miss_store (miss_store)
   );

   function automatic logic [31:0] bmerge(input logic [31:0] base, input logic [31:0] d,
                                          input logic [3:0] be);
      logic [31:0] r = base;
      for (int b = 0; b < 4; b++)
         if (be[b]) r[8*b +: 8] = d[8*b +: 8];
      return r;
   endfunction

   task automatic chk(input bit ok, input string req, input longint act, input longint exp);
      nchk++;
      if (!ok) begin
         nfail++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   // driver: one request per cycle, expectations queued for the monitor
   task automatic cyc(input logic v, input logic st, input logic [AW-1:0] a,
                      input logic [31:0] d, input logic [3:0] be, input logic hit,
                      input int exp_wr, input string req);
      logic [IW-1:0] ix = a[IW+1:2];
      wr_t           e;
      logic [31:0]   nv;
      @(negedge clk);
      req_valid = v; req_store = st; req_addr = a; req_wdata = d; req_be = be; tag_hit = hit;
      if (v && st && hit) begin
         e.idx = ix; e.d = d; e.be = be;
         wq.push_back(e);
         refidx[ix] = bmerge(refidx[ix], d, be);
      end
      if (v && !st && hit) rq.push_back(refidx[ix]);
      if (v && !hit) mq.push_back({st, a});
      #2;
      if (exp_wr >= 0) chk(dwr_en == exp_wr[0], req, longint'(dwr_en), longint'(exp_wr));
      if (v && !hit) begin
         @(posedge clk); #2;
         nv = $urandom;
         mem[ix] = nv; refidx[ix] = nv; tagm[ix] = a[AW-1:IW+2];
      end
   endtask

   // monitor: pops expectations as results appear
   initial begin
      wr_t         e;
      logic        wr_go;
      logic [IW-1:0] wi;
      logic [31:0] wd;
      logic [3:0]  wb;
      logic [31:0] x;
      logic [AW:0] m;
      forever begin
         @(negedge clk); #3;
         wr_go = 1'b0;
         if (rst_n) begin
            if (req_valid && !req_store && tag_hit)
               chk(!dwr_en, "R5 write during load hit", longint'(dwr_en), 0);
            if (dwr_en) begin
               wr_go = 1'b1; wi = dwr_index; wd = dwr_data; wb = dwr_be;
               if (wq.size() == 0) chk(0, "R2 unexpected write", longint'(dwr_index), -1);
               else begin
                  e = wq.pop_front();
                  chk(dwr_index == e.idx && dwr_data == e.d && dwr_be == e.be,
                      "R2 write content", {dwr_index, dwr_be, dwr_data}, {e.idx, e.be, e.d});
               end
            end
            if (rsp_valid) begin
               if (rq.size() == 0) chk(0, "R8 unexpected response", longint'(rsp_data), -1);
               else begin
                  x = rq.pop_front();
                  chk(rsp_data == x, "R9 load data", longint'(rsp_data), longint'(x));
               end
            end
            if (miss_valid) begin
               if (mq.size() == 0) chk(0, "R8 unexpected miss", longint'(miss_addr), -1);
               else begin
                  m = mq.pop_front();
                  chk({miss_store, miss_addr} == m, "R8 miss report",
                      longint'({miss_store, miss_addr}), longint'(m));
               end
            end
         end
         @(posedge clk); #1;
         if (wr_go) mem[wi] = bmerge(mem[wi], wd, wb);
      end
   end

   initial begin
      #(8 * 200000);
      nfail++;
      $display("FAIL watchdog (all requirements): actual hung, expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
   end

   initial begin
      for (int i = 0; i < 2**IW; i++) begin
         mem[i] = 32'h1111_1111 * (i + 1);
         refidx[i] = 32'h1111_1111 * (i + 1);
         tagm[i] = '0;
      end
      repeat (3) @(negedge clk);
      chk(!dwr_en && !rsp_valid && !miss_valid, "R1 outputs in reset",
          longint'({dwr_en, rsp_valid, miss_valid}), 0);
      rst_n = 1'b1;
      cyc(0, 0, 0, 0, 0, 0, 0, "R1 idle after reset");
      // back-to-back stores, bypass, idle commit
      cyc(1, 1, 12'd4,  32'hA1A2_A3A4, 4'hF, 1, 0, "R2 no write in own cycle");
      cyc(1, 1, 12'd8,  32'hB1B2_B3B4, 4'h3, 1, 1, "R3 overlap write");
      cyc(1, 0, 12'd8,  0, 0, 1, 0, "R5 load hit holds port");
      cyc(1, 0, 12'd4,  0, 0, 1, 0, "R4 second load keeps slot");
      cyc(0, 0, 0, 0, 0, 0, 1, "R6 idle commits");
      cyc(0, 0, 0, 0, 0, 0, 0, "R6 nothing left");
      // store miss drains
      cyc(1, 1, 12'd12, 32'hC0C0_C0C0, 4'h6, 1, 0, "R2 park");
      cyc(1, 1, 12'd84, 32'hDEAD_BEEF, 4'hF, 0, 1, "R7 drain on store miss");
      cyc(0, 0, 0, 0, 0, 0, 0, "R7 store miss not retained");
      // load miss drains, no response
      cyc(1, 1, 12'd16, 32'h4444_4444, 4'h9, 1, 0, "R2 park");
      cyc(1, 0, 12'd88, 0, 0, 0, 1, "R7 drain on load miss");
      cyc(0, 0, 0, 0, 0, 0, 0, "R8 load miss silent");
      // partial stores to one word, then bypassed load
      cyc(1, 1, 12'd28, 32'h0000_0077, 4'h1, 1, 0, "R2 park");
      cyc(1, 1, 12'd28, 32'h0099_0000, 4'h4, 1, 1, "R3 same word overlap");
      cyc(1, 0, 12'd28, 0, 0, 1, 0, "R9 merged bypass");
      cyc(0, 0, 0, 0, 0, 0, 1, "R6 idle commits");
      cyc(0, 0, 0, 0, 0, 0, 0, "R6 nothing left");
      // random traffic over eight words folding onto four lines
      for (int n = 0; n < 800; n++) begin
         int unsigned   k = $urandom % 10;
         int unsigned   w = ($urandom % 4) + 16 * ($urandom % 2);
         logic [AW-1:0] a = AW'(w * 4);
         logic          hit = (tagm[a[IW+1:2]] == a[AW-1:IW+2]);
         if (k < 2)      cyc(0, 0, 0, 0, 0, 0, -1, "R6");
         else if (k < 6) cyc(1, 0, a, 0, 0, hit, -1, "R9");
         else            cyc(1, 1, a, $urandom, 4'(($urandom % 15) + 1), hit, -1, "R2");
      end
      cyc(0, 0, 0, 0, 0, 0, -1, "R6");
      cyc(0, 0, 0, 0, 0, 0, -1, "R6");
      cyc(0, 0, 0, 0, 0, 0, 0, "R6 drained after traffic");
      @(negedge clk); #3;
      chk(wq.size() == 0, "R6 writes outstanding", wq.size(), 0);
      chk(rq.size() == 0, "R9 responses outstanding", rq.size(), 0);
      chk(mq.size() == 0, "R8 misses outstanding", mq.size(), 0);
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
   end

endmodule